// File: doc/BRIEF.md
# Cathode Black-Level Loop Sequencer

This block schedules the black-level stabilization loop of a picture tube and manages the tube's switch-on sequence. Inside each vertical blanking interval it counts line strobes. It opens a four-line measurement window at the end of blanking. The first window line measures leakage, and each of the next three lines serves one gun: red, then green, then blue. The analog current sensing and the gun level trimming sit outside the block. They take the window flag and the two-bit phase code from here.

At power-up the picture stays blanked and the beam-current-limit input stays clamped. After a first delay, counted in millisecond ticks from a prescaler, measuring pulses are allowed inside the window lines. The loop switches on when the current comparator reports, during such a line, that the tube draws more than the warm-up threshold. A second delay after that releases the blanking and the clamp.

A vertical-deflection guard failure forces blanking and latches a no-deflection status bit, which stays set until a status read. An override bit disables both effects.

Top module: `cathode_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, measActive, measPulseEn, loopOn and noDefl are 0, and rgbBlank and bclClamp are 1.
- R2: Counting the line strobes seen since vBlank rose as lines 1..VB_LINES, the window covers lines VB_LINES-3 through VB_LINES only. Outputs follow one cycle after the strobe that starts a line. No window line exists once vBlank is low or after line VB_LINES.
- R3: Inside the window the phase output is 2'b00 (leakage), 2'b01 (red), 2'b10 (green) and 2'b11 (blue), in that order, one code per line.
- R4: measPulseEn is 0 until PULSE_WAIT_MS msTick cycles have been counted after reset. From then on it is 1 exactly on window lines.
- R5: While measuring pulses are allowed, curAboveThr high on a window line sets loopOn from the next cycle onward. curAboveThr has no effect before the first delay has elapsed, and none outside window lines.
- R6: RELEASE_WAIT_MS msTick cycles after loopOn rises, rgbBlank (absent a guard trip) and bclClamp fall. After RELEASE_WAIT_MS-1 ticks both are still 1. Once released they stay released.
- R7: measActive is 1 only on window lines while loopOn is 1.
- R8: With defFail high and guardOverride low, rgbBlank is 1 in the same cycle, and noDefl is 1 from the next cycle.
- R9: With guardOverride high, defFail neither blanks the outputs nor sets noDefl.
- R10: noDefl stays 1 until a statusRead cycle clears it. A guard trip in the same cycle as the read keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vBlank | input | 1 | High during vertical blanking |
| lineStart | input | 1 | One-cycle strobe at each line start |
| msTick | input | 1 | One-cycle strobe per millisecond |
| curAboveThr | input | 1 | Comparator: measured cathode current above warm-up threshold |
| defFail | input | 1 | Vertical deflection guard failure |
| guardOverride | input | 1 | Disables the guard's blanking and status effect |
| statusRead | input | 1 | Status read strobe, clears noDefl |
| measActive | output | 1 | Loop measurement line, phase valid |
| phase | output | 2 | 00 leakage, 01 red, 10 green, 11 blue |
| measPulseEn | output | 1 | Measuring pulse drive allowed on this line |
| loopOn | output | 1 | Stabilization loop active |
| rgbBlank | output | 1 | Blank RGB outputs |
| bclClamp | output | 1 | Clamp beam-current-limit input |
| noDefl | output | 1 | Sticky no-deflection status |

## Verification
On every cycle the assertions check several properties. The phase advances only by one step inside a window. Measuring pulses appear only during blanking, and measurement lines only with the loop on. A guard trip blanks at once and latches the status. The status bit holds until a read, and a released clamp never re-engages. The two delays are counted in ticks. Only the directed scenarios can show their exact lengths, the window's position within blanking, and that the comparator is ignored before the first delay and outside window lines.

// File: rtl/cathode_seq_pkg.sv
package cathode_seq_pkg;

  typedef enum logic [1:0] {
    ST_PREHEAT = 2'd0,
    ST_DETECT  = 2'd1,
    ST_SETTLE  = 2'd2,
    ST_RUN     = 2'd3
  } seqState_t;

  typedef struct packed {
    logic msClear;   // zero the millisecond counter
    logic msCount;   // advance the millisecond counter
    logic longWait;  // compare against the release delay
  } ctlStrobe_t;

endpackage

// File: rtl/cathode_seq_dp.sv
module cathode_seq_dp
  import cathode_seq_pkg::*;
#(
  parameter int VB_LINES        = 20,
  parameter int PULSE_WAIT_MS   = 500,
  parameter int RELEASE_WAIT_MS = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vBlank,
  input  logic       lineStart,
  input  logic       defFail,
  input  logic       guardOverride,
  input  logic       statusRead,
  input  ctlStrobe_t ctl,
  output logic       slot,
  output logic [1:0] phase,
  output logic       msDone,
  output logic       guardTrip,
  output logic       noDefl
);

  localparam int LINE_W  = $clog2(VB_LINES + 2);
  localparam int MAX_MS  = (PULSE_WAIT_MS > RELEASE_WAIT_MS) ? PULSE_WAIT_MS : RELEASE_WAIT_MS;
  localparam int WAIT_W  = $clog2(MAX_MS + 1);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(VB_LINES - 3);
  localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(VB_LINES);
  localparam logic [LINE_W-1:0] SAT_LINE   = LINE_W'(VB_LINES + 1);
  localparam logic [WAIT_W-1:0] SHORT_END  = WAIT_W'(PULSE_WAIT_MS - 1);
  localparam logic [WAIT_W-1:0] LONG_END   = WAIT_W'(RELEASE_WAIT_MS - 1);

  logic [LINE_W-1:0] lineCnt;
  logic [WAIT_W-1:0] msCnt;

  // lines seen since blanking began, saturating past the last line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   lineCnt <= '0;
    else if (!vBlank)                            lineCnt <= '0;
    else if (lineStart && lineCnt != SAT_LINE)   lineCnt <= lineCnt + 1'b1;
  end

  assign slot  = vBlank && (lineCnt >= FIRST_LINE) && (lineCnt <= LAST_LINE);
  assign phase = 2'(lineCnt - FIRST_LINE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            msCnt <= '0;
    else if (ctl.msClear) msCnt <= '0;
    else if (ctl.msCount) msCnt <= msCnt + 1'b1;
  end

  assign msDone = (msCnt == (ctl.longWait ? LONG_END : SHORT_END));

  assign guardTrip = defFail && !guardOverride;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           noDefl <= 1'b0;
    else if (guardTrip)  noDefl <= 1'b1;
    else if (statusRead) noDefl <= 1'b0;
  end

endmodule

// File: rtl/cathode_seq_ctl.sv
module cathode_seq_ctl
  import cathode_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       curAboveThr,
  input  logic       slot,
  input  logic       msDone,
  output ctlStrobe_t ctl,
  output logic       loopOn,
  output logic       pulseAllowed,
  output logic       startupHold
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PREHEAT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_PREHEAT: begin
        ctl.msCount = msTick;
        if (msTick && msDone) begin
          stateNext   = ST_DETECT;
          ctl.msClear = 1'b1;
        end
      end
      ST_DETECT: begin
        if (slot && curAboveThr) begin
          stateNext   = ST_SETTLE;
          ctl.msClear = 1'b1;
        end
      end
      ST_SETTLE: begin
        ctl.longWait = 1'b1;
        ctl.msCount  = msTick;
        if (msTick && msDone) begin
          stateNext   = ST_RUN;
          ctl.msClear = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  assign loopOn       = (state == ST_SETTLE) || (state == ST_RUN);
  assign pulseAllowed = (state != ST_PREHEAT);
  assign startupHold  = (state != ST_RUN);

endmodule

// File: rtl/cathode_seq.sv
module cathode_seq
  import cathode_seq_pkg::*;
#(
  parameter int VB_LINES        = 20,
  parameter int PULSE_WAIT_MS   = 500,
  parameter int RELEASE_WAIT_MS = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vBlank,
  input  logic       lineStart,
  input  logic       msTick,
  input  logic       curAboveThr,
  input  logic       defFail,
  input  logic       guardOverride,
  input  logic       statusRead,
  output logic       measActive,
  output logic [1:0] phase,
  output logic       measPulseEn,
  output logic       loopOn,
  output logic       rgbBlank,
  output logic       bclClamp,
  output logic       noDefl
);

  ctlStrobe_t ctl;
  logic slot, msDone, guardTrip, pulseAllowed, startupHold;

  cathode_seq_dp #(
    .VB_LINES(VB_LINES),
    .PULSE_WAIT_MS(PULSE_WAIT_MS),
    .RELEASE_WAIT_MS(RELEASE_WAIT_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .vBlank(vBlank), .lineStart(lineStart),
    .defFail(defFail), .guardOverride(guardOverride), .statusRead(statusRead),
    .ctl(ctl), .slot(slot), .phase(phase), .msDone(msDone),
    .guardTrip(guardTrip), .noDefl(noDefl)
  );

  cathode_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .curAboveThr(curAboveThr),
    .slot(slot), .msDone(msDone), .ctl(ctl), .loopOn(loopOn),
    .pulseAllowed(pulseAllowed), .startupHold(startupHold)
  );

  assign measActive  = slot && loopOn;
  assign measPulseEn = slot && pulseAllowed;
  assign rgbBlank    = startupHold || guardTrip;
  assign bclClamp    = startupHold;

endmodule

// File: rtl/cathode_seq_chk.sv
module cathode_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       vBlank,
  input logic       defFail,
  input logic       guardOverride,
  input logic       statusRead,
  input logic       measActive,
  input logic [1:0] phase,
  input logic       measPulseEn,
  input logic       loopOn,
  input logic       rgbBlank,
  input logic       bclClamp,
  input logic       noDefl
);

  // R2
  pulse_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    measPulseEn |-> vBlank);

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (measActive && $past(measActive) && phase != $past(phase)) |-> phase == $past(phase) + 2'd1);

  // R7
  meas_needs_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    measActive |-> loopOn);

  // R8
  trip_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (defFail && !guardOverride) |-> rgbBlank);

  // R8
  trip_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (defFail && !guardOverride) |=> noDefl);

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (noDefl && !statusRead) |=> noDefl);

  // R6
  clamp_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bclClamp |=> !bclClamp);

  // R6
  loop_stays_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopOn |=> loopOn);

endmodule

bind cathode_seq cathode_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .vBlank(vBlank), .defFail(defFail),
  .guardOverride(guardOverride), .statusRead(statusRead),
  .measActive(measActive), .phase(phase), .measPulseEn(measPulseEn),
  .loopOn(loopOn), .rgbBlank(rgbBlank), .bclClamp(bclClamp), .noDefl(noDefl)
);

// File: tb/cathode_seq_tb.sv
module cathode_seq_tb;

  localparam int VBL = 8;
  localparam int PWT = 6;
  localparam int RWT = 10;
  localparam int FIRST = VBL - 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vBlank = 1'b0, lineStart = 1'b0, msTick = 1'b0, curAboveThr = 1'b0;
  logic defFail = 1'b0, guardOverride = 1'b0, statusRead = 1'b0;
  logic measActive, measPulseEn, loopOn, rgbBlank, bclClamp, noDefl;
  logic [1:0] phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cathode_seq #(.VB_LINES(VBL), .PULSE_WAIT_MS(PWT), .RELEASE_WAIT_MS(RWT)) u_dut (
    .clk(clk), .rstN(rstN), .vBlank(vBlank), .lineStart(lineStart), .msTick(msTick),
    .curAboveThr(curAboveThr), .defFail(defFail), .guardOverride(guardOverride),
    .statusRead(statusRead), .measActive(measActive), .phase(phase),
    .measPulseEn(measPulseEn), .loopOn(loopOn), .rgbBlank(rgbBlank),
    .bclClamp(bclClamp), .noDefl(noDefl)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    msTick = 1'b1;
    repeat (n) @(negedge clk);
    msTick = 1'b0;
  endtask

  // one blanking interval; hitLine raises the comparator on that line
  task automatic runFrame(input bit pulseOn, input bit measOn, input int hitLine,
                          input bit loopAfterHit);
    bit meas = measOn;
    vBlank = 1'b1;
    @(negedge clk);
    for (int l = 1; l <= VBL + 1; l++) begin
      bit inWin = (l >= FIRST) && (l <= VBL);
      lineStart = 1'b1;
      @(negedge clk);
      lineStart = 1'b0;
      check($sformatf("R2/R4 pulse line %0d", l), measPulseEn, int'(pulseOn && inWin));
      check($sformatf("R2/R7 meas line %0d", l), measActive, int'(meas && inWin));
      if (inWin && (pulseOn || meas))
        check($sformatf("R3 phase line %0d", l), phase, l - FIRST);
      if (hitLine == l) begin
        curAboveThr = 1'b1;
        @(negedge clk);
        curAboveThr = 1'b0;
        check($sformatf("R5 loopOn after hit line %0d", l), loopOn, int'(loopAfterHit));
        if (loopAfterHit) meas = 1'b1;
      end
      @(negedge clk);
    end
    vBlank = 1'b0;
    @(negedge clk);
    check("R2 no window after blanking", measPulseEn, 0);
  endtask

  task automatic tReset();
    check("R1 measActive", measActive, 0);
    check("R1 measPulseEn", measPulseEn, 0);
    check("R1 loopOn", loopOn, 0);
    check("R1 noDefl", noDefl, 0);
    check("R1 rgbBlank", rgbBlank, 1);
    check("R1 bclClamp", bclClamp, 1);
  endtask

  task automatic tPreheat();
    // comparator on a window line before the first delay: ignored (R5)
    runFrame(1'b0, 1'b0, FIRST + 1, 1'b0);
    ticks(PWT - 1);
    runFrame(1'b0, 1'b0, 0, 1'b0);  // R4 one tick short
    ticks(1);
    // pulses now on; comparator outside the window is ignored (R5)
    runFrame(1'b1, 1'b0, 2, 1'b0);
    check("R5 loop still off", loopOn, 0);
  endtask

  task automatic tActivate();
    runFrame(1'b1, 1'b0, FIRST + 1, 1'b1);
    check("R5 loopOn held", loopOn, 1);
    check("R6 still blanked", rgbBlank, 1);
    check("R6 still clamped", bclClamp, 1);
  endtask

  task automatic tRelease();
    ticks(RWT - 1);
    check("R6 blank before delay end", rgbBlank, 1);
    check("R6 clamp before delay end", bclClamp, 1);
    ticks(1);
    check("R6 blank released", rgbBlank, 0);
    check("R6 clamp released", bclClamp, 0);
    runFrame(1'b1, 1'b1, 0, 1'b1);
    check("R6 stays released", bclClamp, 0);
  endtask

  task automatic tGuard();
    defFail = 1'b1;
    #1;
    check("R8 immediate blank", rgbBlank, 1);
    @(negedge clk);
    check("R8 status set", noDefl, 1);
    defFail = 1'b0;
    #1;
    check("R8 blank follows guard", rgbBlank, 0);
    repeat (3) @(negedge clk);
    check("R10 status sticky", noDefl, 1);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    check("R10 cleared by read", noDefl, 0);
  endtask

  task automatic tOverride();
    guardOverride = 1'b1;
    defFail = 1'b1;
    #1;
    check("R9 no blank under override", rgbBlank, 0);
    repeat (2) @(negedge clk);
    check("R9 no status under override", noDefl, 0);
    defFail = 1'b0;
    guardOverride = 1'b0;
    @(negedge clk);
  endtask

  task automatic tSetWins();
    defFail = 1'b1;
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    defFail = 1'b0;
    check("R10 trip beats read", noDefl, 1);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    check("R10 later read clears", noDefl, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPreheat();
    tActivate();
    tRelease();
    tGuard();
    tOverride();
    tSetWins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule